// File: doc/BRIEF.md
# Addressable-LED Stream Register Frontend

This block sits between a 32-bit register bus and the waveform encoder of an addressable-LED strip driver. Software (or a DMA engine) programs the pixel order, the bit timing and the reset-gap timing, then starts a frame by setting the enable bit with a non-zero pixel count. Pixel words written to the data port are queued in a 32-entry FIFO and handed to the encoder through a valid/ready pair. The block counts the pixels the encoder takes and, once the last one has gone and the encoder reports the end of the trailing reset gap, it ends the frame and raises a finished event.

One programmable FIFO level drives two refill paths. With DMA selected, a level request line stays high while the FIFO is at or below the level. With DMA off, the same condition sets a CPU-refill event bit instead. The status word shows the live FIFO fill count next to the write-one-to-clear event bits. The interrupt line combines a global enable with the per-event enables.

Top module: `ledstrip_regfront`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0, the status fill field and finished bit read 0, and `irq`, `dma_req`, `pix_valid` and `frame_start` are low.
- R2: The offsets are 0x00 control, 0x04 bit timing, 0x0C reset timing, 0x14 data, 0x18 DMA control and 0x1C interrupt enable. A written value reads back through the register and appears on the matching `cfg_*` output. The fields are: control order [8:6] and length [28:16]; reset timing gap [28:16] and LED count [9:0]; DMA enable [5] and level [4:0]; interrupt global [5], refill [1] and finished [0].
- R3: While idle, a control write with bit 0 set and a non-zero length [28:16] starts a frame. This empties the FIFO and pulses `frame_start` for the one cycle after the write. A length of 0 starts nothing.
- R4: While a frame runs, control writes have no effect, and control bit 0 reads 1.
- R5: Each write to offset 0x14 pushes one word. Words leave on `pix_data` in write order, only during a frame, and at most length words per frame.
- R6: A data write while the FIFO holds 32 words is dropped. It sets a sticky overflow bit (status bit 2), which is cleared by writing 1 to it.
- R7: `dma_req` is high exactly when DMA is enabled and the fill count is at or below the level.
- R8: With DMA disabled and the fill count at or below the level, status bit 1 is set. Writing 1 to it clears it. It is never set while DMA is enabled.
- R9: After length pixels are taken and `gap_done` pulses, status bit 0 is set and control bit 0 returns to 0.
- R10: `irq` equals the global enable ANDed with ((status bit 0 AND finished enable) OR (status bit 1 AND refill enable)).
- R11: Status bits [15:10] (offset 0x20) show the current FIFO fill count, 0 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| pix_valid | output | 1 | Pixel word available to encoder |
| pix_ready | input | 1 | Encoder takes the pixel word |
| pix_data | output | 32 | Pixel word |
| gap_done | input | 1 | Encoder finished trailing reset gap |
| frame_start | output | 1 | One-cycle frame start strobe |
| cfg_order | output | 3 | Pixel colour order |
| cfg_bit_timing | output | 32 | Bit timing word |
| cfg_gap_len | output | 13 | Reset gap length in clocks |
| cfg_led_count | output | 10 | LED count |
| dma_req | output | 1 | DMA refill request |
| irq | output | 1 | Interrupt |

## Verification
The FIFO is filled to several depths: one word, levels just below, at and above the trigger level, 31 words, and completely full. Each depth runs under both DMA enabled and DMA disabled, so the checks show whether the boundary comparison is inclusive and whether the request goes to the DMA line or to the CPU refill bit. Every filled FIFO is then drained through the encoder port. This confirms the word order, that the pixel count stops at the programmed length, and that the frame ends only on the gap pulse. Directed cases cover overflow, a zero length, control writes during a frame, the flush at start and the interrupt gating.

// File: rtl/ledstrip_regfront.sv
module ledstrip_regfront #(
  parameter int DEPTH = 32,
  parameter int LENW  = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pix_valid,
  input  logic        pix_ready,
  output logic [31:0] pix_data,
  input  logic        gap_done,
  output logic        frame_start,
  output logic [2:0]  cfg_order,
  output logic [31:0] cfg_bit_timing,
  output logic [12:0] cfg_gap_len,
  output logic [9:0]  cfg_led_count,
  output logic        dma_req,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]     mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   fill;
  logic [LENW-1:0] len, sent;
  logic            active, dma_en, g_en, e_req, e_fin, s_req, s_fin, s_ovf;
  logic [4:0]      level;

  wire wr      = bus_valid && bus_write;
  wire wr_ctl  = wr && bus_addr == 8'h00;
  wire wr_dat  = wr && bus_addr == 8'h14;
  wire wr_sts  = wr && bus_addr == 8'h20;
  wire start   = wr_ctl && !active && bus_wdata[0] && bus_wdata[16 +: LENW] != '0;
  wire full    = fill == CW'(DEPTH);
  wire push    = wr_dat && !full;
  wire pop     = pix_valid && pix_ready;
  wire at_lvl  = fill <= CW'(level);
  wire finish  = active && sent == len && gap_done;
  wire [5:0] fill6 = 6'(fill);

  assign pix_valid = active && fill != '0 && sent != len;
  assign pix_data  = mem[rp];
  assign dma_req   = dma_en && at_lvl;
  assign irq       = g_en && ((s_fin && e_fin) || (s_req && e_req));

  always_ff @(posedge clk) if (push) mem[wp] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0; sent <= '0; len <= '0; active <= 1'b0;
      cfg_order <= '0; cfg_bit_timing <= '0; cfg_gap_len <= '0; cfg_led_count <= '0;
      dma_en <= 1'b0; level <= '0; g_en <= 1'b0; e_req <= 1'b0; e_fin <= 1'b0;
      s_req <= 1'b0; s_fin <= 1'b0; s_ovf <= 1'b0; frame_start <= 1'b0;
    end else begin
      frame_start <= start;
      if (start) begin
        wp <= '0; rp <= '0; fill <= '0; sent <= '0; active <= 1'b1;
      end else begin
        if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
        if (pop) begin
          rp   <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
          sent <= sent + 1'b1;
        end
        fill <= fill + CW'(push) - CW'(pop);
        if (finish) active <= 1'b0;
      end
      if (wr_ctl && !active) begin
        cfg_order <= bus_wdata[8:6];
        len       <= bus_wdata[16 +: LENW];
      end
      if (wr && bus_addr == 8'h04) cfg_bit_timing <= bus_wdata;
      if (wr && bus_addr == 8'h0C) begin
        cfg_gap_len   <= bus_wdata[28:16];
        cfg_led_count <= bus_wdata[9:0];
      end
      if (wr && bus_addr == 8'h18) begin
        dma_en <= bus_wdata[5];
        level  <= bus_wdata[4:0];
      end
      if (wr && bus_addr == 8'h1C) begin
        g_en <= bus_wdata[5]; e_req <= bus_wdata[1]; e_fin <= bus_wdata[0];
      end
      if (wr_sts && bus_wdata[0]) s_fin <= 1'b0;
      else if (finish)            s_fin <= 1'b1;
      if (wr_sts && bus_wdata[1]) s_req <= 1'b0;
      else if (!dma_en && at_lvl) s_req <= 1'b1;
      if (wr_sts && bus_wdata[2]) s_ovf <= 1'b0;
      else if (wr_dat && full)    s_ovf <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      8'h00:   bus_rdata = {3'b0, 13'(len), 7'b0, cfg_order, 5'b0, active};
      8'h04:   bus_rdata = cfg_bit_timing;
      8'h0C:   bus_rdata = {3'b0, cfg_gap_len, 6'b0, cfg_led_count};
      8'h18:   bus_rdata = {26'b0, dma_en, level};
      8'h1C:   bus_rdata = {26'b0, g_en, 3'b0, e_req, e_fin};
      8'h20:   bus_rdata = {16'b0, fill6, 7'b0, s_ovf, s_req, s_fin};
      default: bus_rdata = '0;
    endcase
  end

  a_r3_empty_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> fill == '0);
  a_r5_no_pixel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !pix_valid);
  a_r6_full_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_dat && !wr_sts) |=> s_ovf);
  a_r7_dma_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> dma_en);
  a_r9_end_sets_finished: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> s_fin);
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> g_en);
endmodule

// File: tb/ledstrip_regfront_tb.sv
`timescale 1ns/1ps
module ledstrip_regfront_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, pix_ready = 0, gap_done = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata, pix_data, cfg_bit_timing;
  logic pix_valid, frame_start, dma_req, irq;
  logic [2:0] cfg_order;
  logic [12:0] cfg_gap_len;
  logic [9:0] cfg_led_count;
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ledstrip_regfront dut_i (.*);

  // {level[4:0], dma_en, npush[5:0], exp_dma_req, exp_refill_bit}
  localparam logic [13:0] VEC [7] = '{
    {5'd16, 1'b1, 6'd4,  1'b1, 1'b0},
    {5'd16, 1'b1, 6'd20, 1'b0, 1'b0},
    {5'd16, 1'b0, 6'd16, 1'b0, 1'b1},
    {5'd16, 1'b0, 6'd17, 1'b0, 1'b0},
    {5'd0,  1'b0, 6'd1,  1'b0, 1'b0},
    {5'd31, 1'b1, 6'd31, 1'b1, 1'b0},
    {5'd31, 1'b1, 6'd32, 1'b0, 1'b0}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic drain(input int n, input logic [31:0] base, input string tag);
    @(negedge clk); pix_ready = 1;
    for (int k = 0; k < n; k++) begin
      chk(pix_valid && pix_data == (base | 32'(k)), tag, pix_data, base | 32'(k));
      @(posedge clk); #1;
    end
    pix_ready = 0;
  endtask

  task automatic end_frame;
    @(negedge clk); gap_done = 1;
    @(posedge clk); #1; gap_done = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(8'h00, r); chk(r == 0, "R1 ctrl", r, 0);
    rd(8'h20, r); chk(r[15:10] == 0 && r[0] == 0, "R1 status", r, 0);
    chk({irq, dma_req, pix_valid, frame_start} == 0, "R1 outputs",
        {irq, dma_req, pix_valid, frame_start}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2 configuration registers
    wr(8'h04, 32'h1234_5678);
    wr(8'h0C, {3'b0, 13'd1500, 6'b0, 10'd300});
    rd(8'h04, r); chk(r == 32'h1234_5678 && cfg_bit_timing == r, "R2 timing", r, 32'h1234_5678);
    rd(8'h0C, r); chk(cfg_gap_len == 13'd1500 && cfg_led_count == 10'd300 && r[28:16] == 1500,
                      "R2 reset timing", r, {3'b0, 13'd1500, 6'b0, 10'd300});
    wr(8'h1C, 32'h21);
    rd(8'h1C, r); chk(r == 32'h21, "R2 int enable", r, 32'h21);

    // vector table: fill levels, DMA vs CPU refill, drain, finish
    foreach (VEC[i]) begin
      automatic logic [4:0] lvl = VEC[i][13:9];
      automatic logic de = VEC[i][8];
      automatic int n = int'(VEC[i][7:2]);
      automatic logic [31:0] base = 32'hA500_0000 | (32'(i) << 8);
      wr(8'h18, {26'b0, de, lvl});
      wr(8'h00, (32'(n) << 16) | 32'h1);
      chk(frame_start, "R3 start pulse", frame_start, 1);
      @(posedge clk); #1;
      chk(!frame_start, "R3 single pulse", frame_start, 0);
      for (int k = 0; k < n; k++) wr(8'h14, base | 32'(k));
      rd(8'h20, r); chk(r[15:10] == 6'(n), "R11 fill count", 32'(r[15:10]), n);
      wr(8'h20, 32'h3);
      @(posedge clk); #1;
      chk(dma_req == VEC[i][1], "R7 dma_req level", dma_req, VEC[i][1]);
      rd(8'h20, r); chk(r[1] == VEC[i][0], "R8 refill bit", r[1], VEC[i][0]);
      drain(n, base, "R5 pixel order");
      chk(!pix_valid, "R5 stop at length", pix_valid, 0);
      rd(8'h00, r); chk(r[0], "R9 running until gap", r[0], 1);
      end_frame();
      rd(8'h00, r); chk(!r[0], "R9 enable clears", r[0], 0);
      rd(8'h20, r); chk(r[0], "R9 finished bit", r[0], 1);
      chk(irq, "R10 finish irq", irq, 1);
      wr(8'h20, 32'h7);
      chk(!irq, "R10 irq after clear", irq, 0);
    end

    // R3 zero length starts nothing
    wr(8'h00, 32'h1);
    chk(!frame_start, "R3 zero length pulse", frame_start, 0);
    rd(8'h00, r); chk(!r[0], "R3 zero length idle", r, 0);

    // R3 flush at start
    wr(8'h18, 32'h0);
    wr(8'h14, 32'h1); wr(8'h14, 32'h2); wr(8'h14, 32'h3);
    rd(8'h20, r); chk(r[15:10] == 3, "R11 idle fill", 32'(r[15:10]), 3);
    wr(8'h00, 32'h0001_00C1);
    rd(8'h20, r); chk(r[15:10] == 0, "R3 flush", 32'(r[15:10]), 0);
    chk(cfg_order == 3, "R2 order", cfg_order, 3);

    // R4 control writes ignored during frame
    wr(8'h00, 32'h0005_0000);
    rd(8'h00, r); chk(r == 32'h0001_00C1, "R4 ctrl locked", r, 32'h0001_00C1);

    // R6 overflow
    for (int k = 0; k < 33; k++) wr(8'h14, 32'hC000_0000 | 32'(k));
    rd(8'h20, r); chk(r[15:10] == 32 && r[2], "R6 full drop", r, 32'h8004);
    wr(8'h20, 32'h4);
    rd(8'h20, r); chk(!r[2], "R6 clear overflow", r[2], 0);
    drain(1, 32'hC000_0000, "R5 one pixel");
    chk(!pix_valid, "R5 length one limit", pix_valid, 0);
    end_frame();
    wr(8'h20, 32'h7);

    // R10 refill irq gating
    wr(8'h18, 32'h1F);
    wr(8'h1C, 32'h22);
    @(posedge clk); #1;
    chk(irq, "R10 refill irq", irq, 1);
    wr(8'h1C, 32'h02);
    chk(!irq, "R10 global off", irq, 0);
    wr(8'h18, 32'h3F);
    wr(8'h20, 32'h2);
    @(posedge clk); #1;
    rd(8'h20, r); chk(!r[1], "R8 no refill with dma", r[1], 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule